// File: doc/BRIEF.md
# Tree Interconnect Routing Station

One node of a tree of shared links that carries many logical channels between distant endpoints. A station serves a set of local senders and local receivers. It has one link up to its parent station and one link down to each of its child stations. Every message is a channel number plus a payload. The station forwards each message to the outputs that lead toward the receivers of its channel, so the endpoints keep their ordinary send and receive behaviour and only see extra latency.

Where a message goes is fixed when the block is built. Three per-channel parameters describe where the receivers sit:
- which local receiver ports hold a receiver for the channel;
- which child subtrees hold one;
- whether the channel is a broadcast channel.

From these, each input port gets a constant table that maps a channel to a mask of destination outputs. The table follows a least-common-ancestor rule, so there is exactly one path between any two endpoints. Every input has its own FIFO. Every output has a round-robin arbiter. A message bound for several outputs leaves its FIFO only after all of them have taken it.

Input index 0 is the parent link, indices 1..NUM_CHILD are the child links, and the local senders follow. Output index 0 is the parent link, indices 1..NUM_CHILD are the child links, and the local receivers follow. Each port uses valid/ready handshakes.

Top module: `tree_route_station`

## Requirements
- R1: While reset is held, and in the first cycle after it, every out_valid bit is 0 and every in_ready bit is 1.
- R2: A unicast message from a local sender or from the parent, whose channel has its receiver in child k's subtree, appears only on output 1+k.
- R3: A unicast message from a local sender or a child, whose channel has no receiver below this station (no local bit and no child bit other than the source child), appears only on output 0 (parent).
- R4: A unicast message arriving from child c, whose receiver lies under another child c2, appears only on output 1+c2.
- R5: A unicast message from any input, whose receiver is local receiver r, appears only on output 1+NUM_CHILD+r.
- R6: A broadcast message appears on every local receiver output and child output whose bit is set for its channel. The source child is excluded. The parent output is also included unless the message came from the parent.
- R7: A message from the parent whose channel has no receiver below this station is dropped. No output goes valid, and the parent input is not stalled.
- R8: A message offered to several outputs is delivered exactly once to each of them. It stays offered, with valid held and channel and payload stable, on every output that has not yet accepted it. The next message from the same input is not offered until every destination has accepted the current one.
- R9: When several inputs compete for one output, grants rotate round-robin over the input index. After reset the search starts at input 0, and after each acceptance it restarts just above the input that was served.
- R10: Messages from one input are delivered on each output in the order they were accepted.
- R11: A message accepted at an input whose FIFO is empty, and whose destinations are idle, is offered on its outputs in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NI | Per-input message valid (0 parent, 1..K children, then local senders) |
| in_ready | output | NI | Per-input space available in its FIFO |
| in_chan | input | NI*CH_W | Per-input channel number |
| in_data | input | NI*PAY_W | Per-input payload |
| out_valid | output | NO | Per-output message valid (0 parent, 1..K children, then local receivers) |
| out_ready | input | NO | Per-output downstream acceptance |
| out_chan | output | NO*CH_W | Per-output channel number |
| out_data | output | NO*PAY_W | Per-output payload |

## Verification
Two functions can fall in the same cycle: the partial delivery of a broadcast, and round-robin arbitration against a unicast that wants one of the broadcast's outputs.

The bench provokes this by having a local sender issue a broadcast while a child sends a unicast to a child output the broadcast also targets. It then judges, cycle by cycle, which payload each output carries. The broadcast must finish its uncontested outputs at once, wait one cycle for the contested one, and then leave its FIFO.

A second overlap comes from stalling the parent output during a broadcast while a later message queues behind it. The bench judges that the later message stays hidden until the stall ends.

// File: rtl/tree_route_pkg.sv
// Shared helpers for the tree routing station.
// Assumes: port roles follow the numbering parent, children, then locals.
package tree_route_pkg;

    typedef enum logic [1:0] {
        ROLE_PARENT = 2'd0,
        ROLE_CHILD  = 2'd1,
        ROLE_LOCAL  = 2'd2
    } port_role_e;

    // Role of an input or output index given the child count.
    function automatic port_role_e role_of(input int idx, input int n_child);
        if (idx == 0)           return ROLE_PARENT;
        else if (idx <= n_child) return ROLE_CHILD;
        else                    return ROLE_LOCAL;
    endfunction

    // Modular successor used by the round-robin pointers.
    function automatic int wrap_next(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/trs_fifo.sv
// Per-input message buffer: circular store with a combinational head.
// Assumes: pop is only asserted while head_valid is high; no push when full.
module trs_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    output logic         head_valid,
    input  logic         pop,
    output logic [W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign push_ready = (count != FULL);
    assign head_valid = (count != '0);
    assign head_data  = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/trs_route_lookup.sv
// Static routing lookup for one input port. The channel-to-destination
// table is computed at elaboration from receiver placement parameters,
// using the least-common-ancestor rule.
// Assumes: unicast channels mark at most one receiver location.
module trs_route_lookup
    import tree_route_pkg::*;
#(
    parameter int SRC       = 0,
    parameter int NUM_CHILD = 2,
    parameter int NUM_LRECV = 2,
    parameter int NUM_CH    = 8,
    parameter int CH_W      = 3,
    parameter int NO        = 5,
    parameter logic [NUM_CH*NUM_LRECV-1:0] CH_LOCAL_RX = '0,
    parameter logic [NUM_CH*NUM_CHILD-1:0] CH_CHILD_RX = '0,
    parameter logic [NUM_CH-1:0]           CH_BCAST    = '0
) (
    input  logic [CH_W-1:0] chan,
    output logic [NO-1:0]   mask
);
    // Builds the full per-channel destination table for this source.
    function automatic logic [NUM_CH*NO-1:0] build_table();
        logic [NUM_CH*NO-1:0] tbl;
        logic [NO-1:0]        m;
        logic                 down;
        port_role_e           src_role;
        tbl      = '0;
        src_role = role_of(SRC, NUM_CHILD);
        for (int c = 0; c < NUM_CH; c++) begin
            m    = '0;
            down = 1'b0;
            for (int k = 0; k < NUM_CHILD; k++) begin
                if (CH_CHILD_RX[c*NUM_CHILD+k] &&
                    !(src_role == ROLE_CHILD && SRC - 1 == k)) begin
                    m[1+k] = 1'b1;
                    down   = 1'b1;
                end
            end
            for (int r = 0; r < NUM_LRECV; r++) begin
                if (CH_LOCAL_RX[c*NUM_LRECV+r]) begin
                    m[1+NUM_CHILD+r] = 1'b1;
                    down             = 1'b1;
                end
            end
            if (src_role != ROLE_PARENT && (CH_BCAST[c] || !down)) m[0] = 1'b1;
            tbl[c*NO +: NO] = m;
        end
        return tbl;
    endfunction

    localparam logic [NUM_CH*NO-1:0] TBL = build_table();

    // Table read for the channel at the head of this input.
    assign mask = TBL[int'(chan)*NO +: NO];
endmodule

// File: rtl/trs_rr_arb.sv
// Round-robin arbiter for one output. A grant is locked while the output
// is valid and not accepted, so the offered message stays stable.
// Assumes: a requester keeps its request until served.
module trs_rr_arb
    import tree_route_pkg::*;
#(
    parameter int N = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N-1:0]                  req,
    input  logic                          ready,
    output logic [N-1:0]                  gnt,
    output logic [(N>1?$clog2(N):1)-1:0]  gnt_idx,
    output logic                          any
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr, lock_idx, pick_idx;
    logic          lock_v, found;

    // Search for the first request at or after the pointer.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                pick_idx = IW'(idx);
            end
        end
    end

    // Locked grant wins over a fresh pick.
    always_comb begin
        gnt_idx = lock_v ? lock_idx : pick_idx;
        any     = lock_v || found;
        gnt     = '0;
        if (any) gnt[gnt_idx] = 1'b1;
    end

    // Pointer advance on acceptance and grant lock under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            lock_v   <= 1'b0;
            lock_idx <= '0;
        end else begin
            lock_v   <= any && !ready;
            lock_idx <= gnt_idx;
            if (any && ready) ptr <= IW'(wrap_next(int'(gnt_idx), N));
        end
    end
endmodule

// File: rtl/tree_route_station.sv
// Routing station of a shared tree interconnect. Inputs: parent link,
// child links, local senders. Outputs: parent link, child links, local
// receivers. Each input is buffered, looks up a static destination mask
// and is released once all destinations accepted; each output arbitrates
// round-robin among inputs that target it.
// Assumes: routing parameters describe a consistent tree.
module tree_route_station #(
    parameter int NUM_CHILD  = 2,
    parameter int NUM_LSEND  = 2,
    parameter int NUM_LRECV  = 2,
    parameter int NUM_CH     = 8,
    parameter int PAY_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter logic [NUM_CH*NUM_LRECV-1:0] CH_LOCAL_RX = 16'h8490,
    parameter logic [NUM_CH*NUM_CHILD-1:0] CH_CHILD_RX = 16'hC809,
    parameter logic [NUM_CH-1:0]           CH_BCAST    = 8'hE0,
    localparam int NI   = 1 + NUM_CHILD + NUM_LSEND,
    localparam int NO   = 1 + NUM_CHILD + NUM_LRECV,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NI-1:0]         in_valid,
    output logic [NI-1:0]         in_ready,
    input  logic [NI*CH_W-1:0]    in_chan,
    input  logic [NI*PAY_W-1:0]   in_data,
    output logic [NO-1:0]         out_valid,
    input  logic [NO-1:0]         out_ready,
    output logic [NO*CH_W-1:0]    out_chan,
    output logic [NO*PAY_W-1:0]   out_data
);
    localparam int MW = CH_W + PAY_W;
    localparam int IW = (NI > 1) ? $clog2(NI) : 1;

    logic [NI-1:0]    h_v;
    logic [CH_W-1:0]  h_chan [NI];
    logic [PAY_W-1:0] h_pay  [NI];
    logic [NO-1:0]    mask   [NI];
    logic [NO-1:0]    done   [NI];
    logic [NO-1:0]    pend   [NI];
    logic [NO-1:0]    acc    [NI];
    logic [NI-1:0]    pop;
    logic [NI-1:0]    req_o  [NO];
    logic [NI-1:0]    gnt_o  [NO];
    logic [IW-1:0]    gidx   [NO];

    // Input side: buffer, route lookup and delivery tracking per input.
    for (genvar i = 0; i < NI; i++) begin : g_in
        logic [MW-1:0] head;

        trs_fifo #(.W(MW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[i]),
            .push_ready (in_ready[i]),
            .push_data  ({in_chan[i*CH_W +: CH_W], in_data[i*PAY_W +: PAY_W]}),
            .head_valid (h_v[i]),
            .pop        (pop[i]),
            .head_data  (head)
        );

        assign h_chan[i] = head[MW-1 -: CH_W];
        assign h_pay[i]  = head[PAY_W-1:0];

        trs_route_lookup #(
            .SRC(i), .NUM_CHILD(NUM_CHILD), .NUM_LRECV(NUM_LRECV),
            .NUM_CH(NUM_CH), .CH_W(CH_W), .NO(NO),
            .CH_LOCAL_RX(CH_LOCAL_RX), .CH_CHILD_RX(CH_CHILD_RX),
            .CH_BCAST(CH_BCAST)
        ) u_lookup (
            .chan (h_chan[i]),
            .mask (mask[i])
        );

        // Remember which destinations already took the head message.
        always_ff @(posedge clk) begin
            if (!rst_n)      done[i] <= '0;
            else if (pop[i]) done[i] <= '0;
            else             done[i] <= done[i] | acc[i];
        end
    end

    // Outstanding destinations and per-output request vectors.
    always_comb begin
        for (int i = 0; i < NI; i++) pend[i] = h_v[i] ? (mask[i] & ~done[i]) : '0;
        for (int o = 0; o < NO; o++)
            for (int i = 0; i < NI; i++) req_o[o][i] = pend[i][o];
    end

    // Acceptances this cycle and release of fully delivered heads.
    always_comb begin
        for (int i = 0; i < NI; i++) begin
            for (int o = 0; o < NO; o++) acc[i][o] = gnt_o[o][i] && out_ready[o];
            pop[i] = h_v[i] && ((pend[i] & ~acc[i]) == '0);
        end
    end

    // Output side: arbiter and data steering per output.
    for (genvar o = 0; o < NO; o++) begin : g_out
        trs_rr_arb #(.N(NI)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_o[o]),
            .ready   (out_ready[o]),
            .gnt     (gnt_o[o]),
            .gnt_idx (gidx[o]),
            .any     (out_valid[o])
        );
        assign out_chan[o*CH_W +: CH_W]   = h_chan[gidx[o]];
        assign out_data[o*PAY_W +: PAY_W] = h_pay[gidx[o]];
    end
endmodule

// File: rtl/tree_route_station_chk.sv
// Property checker for the routing station, attached through bind.
// Assumes: same parameters as the bound instance.
module tree_route_station_chk #(
    parameter int NUM_CHILD  = 2,
    parameter int NUM_LSEND  = 2,
    parameter int NUM_LRECV  = 2,
    parameter int NUM_CH     = 8,
    parameter int PAY_W      = 8,
    parameter logic [NUM_CH*NUM_LRECV-1:0] CH_LOCAL_RX = 16'h8490,
    parameter logic [NUM_CH*NUM_CHILD-1:0] CH_CHILD_RX = 16'hC809,
    parameter logic [NUM_CH-1:0]           CH_BCAST    = 8'hE0,
    localparam int NI   = 1 + NUM_CHILD + NUM_LSEND,
    localparam int NO   = 1 + NUM_CHILD + NUM_LRECV,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NI-1:0]       in_valid,
    input logic [NI-1:0]       in_ready,
    input logic [NI*CH_W-1:0]  in_chan,
    input logic [NI*PAY_W-1:0] in_data,
    input logic [NO-1:0]       out_valid,
    input logic [NO-1:0]       out_ready,
    input logic [NO*CH_W-1:0]  out_chan,
    input logic [NO*PAY_W-1:0] out_data
);
    logic rst_seen;

    // Notes that a reset edge has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    // R1
    always @(negedge clk) begin
        if (rst_seen === 1'b1 && rst_n === 1'b0)
            reset_idle_chk: assert (out_valid == '0 && in_ready == '1);
    end

    for (genvar o = 0; o < NO; o++) begin : g_hold
        // R8
        hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=> out_valid[o]);
        // R8
        hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ready[o]) |=>
            ($stable(out_chan[o*CH_W +: CH_W]) && $stable(out_data[o*PAY_W +: PAY_W])));
    end

    for (genvar k = 0; k < NUM_CHILD; k++) begin : g_child
        // R2
        child_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[1+k] |->
            CH_CHILD_RX[int'(out_chan[(1+k)*CH_W +: CH_W])*NUM_CHILD + k]);
    end

    for (genvar r = 0; r < NUM_LRECV; r++) begin : g_local
        // R5
        local_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[1+NUM_CHILD+r] |->
            CH_LOCAL_RX[int'(out_chan[(1+NUM_CHILD+r)*CH_W +: CH_W])*NUM_LRECV + r]);
    end

    // R3
    parent_unicast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && !CH_BCAST[out_chan[CH_W-1:0]]) |->
        (CH_LOCAL_RX[int'(out_chan[CH_W-1:0])*NUM_LRECV +: NUM_LRECV] == '0));
endmodule

bind tree_route_station tree_route_station_chk #(
    .NUM_CHILD(NUM_CHILD), .NUM_LSEND(NUM_LSEND), .NUM_LRECV(NUM_LRECV),
    .NUM_CH(NUM_CH), .PAY_W(PAY_W),
    .CH_LOCAL_RX(CH_LOCAL_RX), .CH_CHILD_RX(CH_CHILD_RX), .CH_BCAST(CH_BCAST)
) u_chk (.*);

// File: tb/tree_route_station_test.sv
`timescale 1ns/1ps
// Bench: routing vectors from a table, then directed corner-case tests.
module tree_route_station_test;
    localparam int NI = 5, NO = 5, CW = 3, PW = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NI-1:0]   in_valid;
    logic [NI-1:0]   in_ready;
    logic [NI*CW-1:0] in_chan;
    logic [NI*PW-1:0] in_data;
    logic [NO-1:0]   out_valid;
    logic [NO-1:0]   out_ready;
    logic [NO*CW-1:0] out_chan;
    logic [NO*PW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tree_route_station uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data)
    );

    // {src, chan, payload, expected destination mask}
    localparam logic [18:0] VEC [19] = '{
        {3'd3, 3'd0, 8'h10, 5'b00010},
        {3'd3, 3'd1, 8'h11, 5'b00100},
        {3'd4, 3'd2, 8'h12, 5'b01000},
        {3'd4, 3'd3, 8'h13, 5'b10000},
        {3'd3, 3'd4, 8'h14, 5'b00001},
        {3'd4, 3'd5, 8'h15, 5'b01101},
        {3'd3, 3'd6, 8'h16, 5'b00001},
        {3'd4, 3'd7, 8'h17, 5'b10111},
        {3'd1, 3'd1, 8'h21, 5'b00100},
        {3'd2, 3'd0, 8'h22, 5'b00010},
        {3'd1, 3'd2, 8'h23, 5'b01000},
        {3'd2, 3'd3, 8'h24, 5'b10000},
        {3'd1, 3'd4, 8'h25, 5'b00001},
        {3'd1, 3'd7, 8'h26, 5'b10101},
        {3'd2, 3'd5, 8'h27, 5'b01001},
        {3'd0, 3'd7, 8'h31, 5'b10110},
        {3'd0, 3'd5, 8'h32, 5'b01100},
        {3'd0, 3'd4, 8'h33, 5'b00000},
        {3'd0, 3'd1, 8'h34, 5'b00100}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int src, input int ch, input int pay);
        in_valid[src] = 1'b1;
        in_chan[src*CW +: CW] = CW'(ch);
        in_data[src*PW +: PW] = PW'(pay);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = '0; in_chan = '0; in_data = '0; out_ready = '1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = '0; in_chan = '0; in_data = '0; out_ready = '1;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 in_ready in reset", int'(in_ready), 5'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 with one-cycle latency R11
        for (int v = 0; v < 19; v++) begin
            logic [18:0] e;
            e = VEC[v];
            @(negedge clk);
            drive(int'(e[18:16]), int'(e[15:13]), int'(e[12:5]));
            @(negedge clk);
            in_valid = '0;
            check($sformatf("R2 R3 R4 R5 R6 R7 R11 vec%0d mask", v), int'(out_valid), int'(e[4:0]));
            for (int o = 0; o < NO; o++) begin
                if (e[o]) begin
                    check($sformatf("R11 vec%0d out%0d data", v, o),
                          int'(out_data[o*PW +: PW]), int'(e[12:5]));
                    check($sformatf("R11 vec%0d out%0d chan", v, o),
                          int'(out_chan[o*CW +: CW]), int'(e[15:13]));
                end
            end
        end

        // R7: dropped message does not stall the parent input
        do_reset();
        drive(0, 6, 8'h66);
        @(negedge clk);
        in_valid = '0;
        check("R7 drop no output", int'(out_valid), 0);
        check("R7 parent input ready", int'(in_ready[0]), 1);
        drive(0, 2, 8'h22);
        @(negedge clk);
        in_valid = '0;
        check("R7 next msg routed", int'(out_valid), 5'b01000);
        check("R7 next msg data", int'(out_data[3*PW +: PW]), 8'h22);

        // R8 R10: broadcast with parent stalled, later message queued behind
        do_reset();
        out_ready = 5'b11110;
        drive(3, 7, 8'h5A);
        @(negedge clk);
        in_valid = '0;
        check("R6 bcast fanout", int'(out_valid), 5'b10111);
        drive(3, 3, 8'h33);
        @(negedge clk);
        in_valid = '0;
        check("R8 only parent pending", int'(out_valid), 5'b00001);
        check("R8 parent data held", int'(out_data[0 +: PW]), 8'h5A);
        @(negedge clk);
        check("R8 parent still held", int'(out_valid), 5'b00001);
        out_ready = '1;
        @(negedge clk);
        check("R10 queued msg follows", int'(out_valid), 5'b10000);
        check("R10 queued msg data", int'(out_data[4*PW +: PW]), 8'h33);
        @(negedge clk);
        check("R8 delivered once", int'(out_valid), 0);

        // Overlap: broadcast partial delivery vs contention on child1 (R8 R9)
        do_reset();
        drive(3, 5, 8'hC5);
        drive(1, 1, 8'h11);
        @(negedge clk);
        in_valid = '0;
        check("R9 overlap first mask", int'(out_valid), 5'b01101);
        check("R9 child1 serves input1", int'(out_data[2*PW +: PW]), 8'h11);
        check("R6 bcast to parent", int'(out_data[0 +: PW]), 8'hC5);
        @(negedge clk);
        check("R8 bcast remainder", int'(out_valid), 5'b00100);
        check("R8 remainder data", int'(out_data[2*PW +: PW]), 8'hC5);
        @(negedge clk);
        check("R8 bcast released", int'(out_valid), 0);

        // R9 R10: two local senders contend for the parent
        do_reset();
        out_ready = 5'b11110;
        drive(3, 4, 8'hA0);
        drive(4, 4, 8'hB0);
        @(negedge clk);
        drive(3, 4, 8'hA1);
        drive(4, 4, 8'hB1);
        @(negedge clk);
        in_valid = '0;
        out_ready = '1;
        check("R9 grant 1", int'(out_data[0 +: PW]), 8'hA0);
        @(negedge clk);
        check("R9 grant 2", int'(out_data[0 +: PW]), 8'hB0);
        @(negedge clk);
        check("R10 grant 3", int'(out_data[0 +: PW]), 8'hA1);
        @(negedge clk);
        check("R10 grant 4", int'(out_data[0 +: PW]), 8'hB1);
        @(negedge clk);
        check("R9 drained", int'(out_valid), 0);

        finish_run();
    end

    // Watchdog: counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule